// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter

A small synchronous reversible counter, four bits wide by default. Every state bit is updated on the same rising clock edge. A level on the direction input selects counting up or down. A low on the count enable lets the counter step, and a high freezes it. An active-low load input presets the count from the parallel data inputs at once, with no clock edge needed.

Two status outputs let counters be joined into wider ones. The terminal flag goes high when the count sits at the last value for the present direction. The active-low ripple clock pulses low during the low phase of the clock while the stage is enabled and at its terminal value. If that output drives the clock of the next stage, the next stage steps on the same edge that wraps the lower stage. The result is a wider up/down count.

An active-low asynchronous reset clears the count. Its release is synchronized to the clock by a parameterized number of flops. A stage clocked from a ripple clock sets that number to zero.

Top module: `updown_ctr`

## Requirements
- R1: While rst_n is low and load_n is high, q is 0 without waiting for a clock edge. After rst_n rises, the count stays 0 for RST_SYNC_STAGES rising edges and then resumes counting.
- R2: With cnt_en_n=0, dir_down=0 and load_n=1, each rising clock edge adds one to q. The value 15 wraps to 0.
- R3: With cnt_en_n=0, dir_down=1 and load_n=1, each rising clock edge subtracts one from q. The value 0 wraps to 15.
- R4: With cnt_en_n=1, q holds across clock edges for either level of dir_down.
- R5: While load_n is low, q equals din at once and clock edges are ignored. When load_n is released, counting resumes from the loaded value. din[0] and q[0] are the least significant bits.
- R6: term_flag is 1 exactly when q=15 with dir_down=0, or q=0 with dir_down=1, whatever the level of cnt_en_n.
- R7: rco_n is 0 only while clk is low, cnt_en_n is low and term_flag is high. Otherwise it is 1.
- R8: When one stage's rco_n drives the clk of a second stage whose cnt_en_n is tied low, the pair {upper q, lower q} counts as one 8-bit up/down counter. The count wraps across the stage boundary in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| load_n | input | 1 | Active-low asynchronous preset |
| din | input | WIDTH | Preset data, bit 0 least significant |
| q | output | WIDTH | Present count, bit 0 least significant |
| term_flag | output | 1 | High at the terminal value for the present direction |
| rco_n | output | 1 | Active-low ripple clock for cascading |

## Verification
The hardest situation to reach is a carry or borrow crossing between two chained stages. The lower stage must be at its terminal value and enabled, and its clock must go through a full low phase so that the upper stage sees a rising ripple-clock edge. Both stages are preset so the pair starts a few steps below 0xFF. The bench then counts up through the wrap to 0x00, reverses direction and counts back down through the borrow. Direction and enable only change while the clock is high, so the ripple clock never shows a spurious edge.

// File: rtl/updown_ctr_pkg.sv
package updown_ctr_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/ctr_rst_sync.sv
module ctr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out_n
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign rst_out_n = arst_n;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          sync_q <= '0;
        end else begin
          sync_q[0] <= 1'b1;
          for (int i = 1; i < STAGES; i++) begin
            sync_q[i] <= sync_q[i-1];
          end
        end
      end
      assign rst_out_n = sync_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ctr_next.sv
module ctr_next
  import updown_ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             cnt_en_n,
  input  logic             dir_down,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  dir_e dir;
  assign dir = dir_e'(dir_down);

  always_comb begin
    nxt = cur;
    if (!cnt_en_n) begin
      if (dir == DIR_DOWN) nxt = cur - ONE;
      else                 nxt = cur + ONE;
    end
  end
endmodule

// File: rtl/ctr_cascade.sv
module ctr_cascade #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] cur,
  input  logic             dir_down,
  input  logic             cnt_en_n,
  output logic             term_flag,
  output logic             rco_n
);
  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  logic at_top;
  logic at_bot;

  assign at_top    = (cur == TOP_VAL);
  assign at_bot    = (cur == BOT_VAL);
  assign term_flag = dir_down ? at_bot : at_top;
  assign rco_n     = ~(~clk & ~cnt_en_n & term_flag);
endmodule

// File: rtl/updown_ctr.sv
module updown_ctr #(
  parameter int WIDTH           = 4,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_n,
  input  logic             dir_down,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             term_flag,
  output logic             rco_n
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  ctr_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_out_n (rst_sync_n)
  );

  ctr_next #(.WIDTH(WIDTH)) u_next (
    .cur      (cnt_q),
    .cnt_en_n (cnt_en_n),
    .dir_down (dir_down),
    .nxt      (cnt_d)
  );

  // Load captures asynchronously and again on every edge it is held,
  // so the register matches din when load_n is released.
  always_ff @(posedge clk or negedge rst_sync_n or negedge load_n) begin
    if (!rst_sync_n)  cnt_q <= '0;
    else if (!load_n) cnt_q <= din;
    else              cnt_q <= cnt_d;
  end

  // Transparent path while loading: q follows din at once.
  assign q = load_n ? cnt_q : din;

  ctr_cascade #(.WIDTH(WIDTH)) u_casc (
    .clk       (clk),
    .cur       (q),
    .dir_down  (dir_down),
    .cnt_en_n  (cnt_en_n),
    .term_flag (term_flag),
    .rco_n     (rco_n)
  );
endmodule

// File: rtl/updown_ctr_checker.sv
module updown_ctr_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             cnt_en_n,
  input logic             dir_down,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             term_flag
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic past_ok;
  logic ld_seen;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) past_ok <= 1'b0;
    else          past_ok <= 1'b1;
  end

  // Set by any load since the previous edge, cleared at an edge without load.
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) ld_seen <= 1'b1;
    else         ld_seen <= 1'b0;
  end

  assert_load_follows_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !load_n |-> (q == din));

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && load_n && !ld_seen && !$past(cnt_en_n) && !$past(dir_down))
      |-> (q == $past(q) + ONE));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && load_n && !ld_seen && !$past(cnt_en_n) && $past(dir_down))
      |-> (q == $past(q) - ONE));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (past_ok && load_n && !ld_seen && $past(cnt_en_n)) |-> (q == $past(q)));

  assert_term_top_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!dir_down && (q == '1)) |-> term_flag);

  assert_term_bot_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dir_down && (q == '0)) |-> term_flag);

  assert_term_only_ends_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    term_flag |-> ((q == '1) || (q == '0)));
endmodule

bind updown_ctr updown_ctr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .cnt_en_n  (cnt_en_n),
  .dir_down  (dir_down),
  .load_n    (load_n),
  .din       (din),
  .q         (q),
  .term_flag (term_flag)
);

// File: tb/updown_ctr_test.sv
`timescale 1ns/1ps
module updown_ctr_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_n;
  logic       dn;
  logic       ld_n;
  logic [3:0] din_lo;
  logic [3:0] din_hi;
  logic [3:0] q_lo;
  logic [3:0] q_hi;
  logic       term_lo;
  logic       term_hi;
  logic       rco_lo;
  logic       rco_hi;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  updown_ctr #(.WIDTH(4), .RST_SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(en_n), .dir_down(dn), .load_n(ld_n),
    .din(din_lo), .q(q_lo), .term_flag(term_lo), .rco_n(rco_lo)
  );

  updown_ctr #(.WIDTH(4), .RST_SYNC_STAGES(0)) uut_hi (
    .clk(rco_lo), .rst_n(rst_n), .cnt_en_n(1'b0), .dir_down(dn), .load_n(ld_n),
    .din(din_hi), .q(q_hi), .term_flag(term_hi), .rco_n(rco_hi)
  );

  // Fields: en_n, dir_down, load_n, din[3:0], rco_n in low phase before the edge,
  // q after the edge, term_flag after the edge.
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 4'd1,  1'b0}, // R2 up
    {1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 4'd2,  1'b0}, // R2 up
    {1'b0, 1'b0, 1'b0, 4'd13, 1'b1, 4'd13, 1'b0}, // R5 load
    {1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 4'd14, 1'b0}, // R2
    {1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 4'd15, 1'b1}, // R2, R6 top
    {1'b0, 1'b0, 1'b1, 4'd0,  1'b0, 4'd0,  1'b0}, // R2 wrap, R7 low
    {1'b1, 1'b0, 1'b1, 4'd0,  1'b1, 4'd0,  1'b0}, // R4 hold
    {1'b1, 1'b1, 1'b1, 4'd0,  1'b1, 4'd0,  1'b1}, // R4, R6 with enable high
    {1'b0, 1'b1, 1'b1, 4'd0,  1'b0, 4'd15, 1'b0}, // R3 wrap, R7 low
    {1'b0, 1'b1, 1'b1, 4'd0,  1'b1, 4'd14, 1'b0}, // R3
    {1'b0, 1'b1, 1'b0, 4'd1,  1'b1, 4'd1,  1'b0}, // R5 load
    {1'b0, 1'b1, 1'b1, 4'd0,  1'b1, 4'd0,  1'b1}, // R3, R6 bottom
    {1'b1, 1'b0, 1'b1, 4'd0,  1'b1, 4'd0,  1'b0}, // R4 direction change held
    {1'b1, 1'b0, 1'b0, 4'd15, 1'b1, 4'd15, 1'b1}, // R5, R7 high with enable off
    {1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1}, // R5 clock ignored
    {1'b0, 1'b0, 1'b0, 4'd5,  1'b1, 4'd5,  1'b0}, // R5 LSB order
    {1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 4'd6,  1'b0}  // R5 resume
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] exp8;
    rst_n = 1'b0; en_n = 1'b1; dn = 1'b0; ld_n = 1'b1; din_lo = '0; din_hi = '0;
    repeat (3) @(posedge clk);
    #0.5;
    chk("R1 reset q", q_lo, 0);
    chk("R6 reset term", term_lo, 0);
    @(negedge clk); #0.5;
    chk("R7 reset rco", rco_lo, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    for (int k = 0; k < NV; k++) begin
      en_n   = VEC[k][12];
      dn     = VEC[k][11];
      ld_n   = VEC[k][10];
      din_lo = VEC[k][9:6];
      @(negedge clk); #0.5;
      chk($sformatf("R7 rco vec %0d", k), rco_lo, VEC[k][5]);
      @(posedge clk); #0.5;
      chk($sformatf("R2/R3/R4/R5 q vec %0d", k), q_lo, VEC[k][4:1]);
      chk($sformatf("R6 term vec %0d", k), term_lo, VEC[k][0]);
      #0.5;
    end

    // R1: asynchronous clear, then synchronized release.
    en_n = 1'b0; dn = 1'b0; ld_n = 1'b1;
    rst_n = 1'b0;
    #0.5;
    chk("R1 async clear", q_lo, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #0.5;
    chk("R1 sync release edge1", q_lo, 0);
    @(posedge clk); #0.5;
    chk("R1 sync release edge2", q_lo, 0);
    @(posedge clk); #0.5;
    chk("R1 counting resumes", q_lo, 1);
    #0.5;

    // R8: two stages chained through the ripple clock.
    en_n = 1'b0; dn = 1'b0; din_lo = 4'd13; din_hi = 4'd15; ld_n = 1'b0;
    @(posedge clk); #1;
    ld_n = 1'b1;
    exp8 = 8'hFD;
    chk("R8 cascade preset", {q_hi, q_lo}, exp8);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #0.5;
      exp8 = exp8 + 8'd1;
      chk($sformatf("R8 cascade up step %0d", i), {q_hi, q_lo}, exp8);
    end
    #0.5;
    dn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #0.5;
      exp8 = exp8 - 8'd1;
      chk($sformatf("R8 cascade down step %0d", i), {q_hi, q_lo}, exp8);
    end

    summary();
  end
endmodule